// File: doc/BRIEF.md
# Two-Slot Ring-Queue Context Manager

This block holds the hardware context for a small number of ring queues (two by default) that user-mode queues are mapped into and unmapped from. A map command carries a doorbell offset, the memory address of the queue's descriptor and the descriptor fields the block needs. The block claims the lowest free slot and loads it with the ring base, ring size, read pointer, write pointer and read-pointer writeback address. The pointers come from the descriptor, so a queue that was unmapped earlier carries on from where it stopped and does not replay stale packets.

An unmap command finds the slot by doorbell. It writes the slot's live read and write pointers back into the descriptor image in memory through a valid/ready write port, and then frees the slot. A drain command unmaps every occupied slot in ascending order. A progress input lets the fetch engine update a slot's live pointers and mark the slot active. A view port reads back any slot's context.

Top module: `qctx_mgr`

## Requirements
- R1: A map command (cmd_op 0) claims the lowest-numbered invalid slot. If every slot is valid, err_pulse is high for the cycle after acceptance and no slot changes.
- R2: On map, the slot's ring base is cmd_ring_base shifted left by 8 bits, truncated to 64 bits.
- R3: On map, the slot's ring size in bytes is 4 shifted left by cmd_ring_ctl[6:1].
- R4: On map, the slot's writeback address is {cmd_wb_hi, cmd_wb_lo}, with the high word in bits 63:32.
- R5: On map, the slot becomes valid, its busy flag clears, its read and write pointers take cmd_rptr and cmd_wptr, and it stores the key cmd_db_ofs<<2 and the descriptor address.
- R6: An unmap command (cmd_op 1) with key cmd_db_ofs<<2 selects the lowest valid slot whose key matches. It then issues two writes on the memory port: first the read pointer at descriptor+0x10, then the write pointer at descriptor+0x18. Each write holds its address and data until mem_wr_ready is high.
- R7: The slot becomes invalid with key zero at the edge where the second write is accepted. cmd_ready stays low from acceptance until the writeback completes.
- R8: If the selected slot's descriptor address is zero, no write is issued, warn_pulse is high for one cycle, and the slot is freed.
- R9: An unmap that matches no slot raises err_pulse for one cycle and changes no slot.
- R10: A drain command (cmd_op 2) visits slots from 0 upward. It unmaps, as in R6 to R8, each slot whose stored key is nonzero, and leaves every slot invalid.
- R11: After reset every slot is invalid with key zero, cmd_ready is high and no write is pending.
- R12: A progress update (prog_valid) on a valid slot replaces its live read and write pointers and sets its busy flag. A later writeback carries the updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 map, 1 unmap, 2 drain, 3 no-op |
| cmd_db_ofs | input | DBO_W | Doorbell offset; the key is this shifted left by 2 |
| cmd_desc_addr | input | 64 | Descriptor memory address (0 means none) |
| cmd_ring_base | input | 64 | Descriptor ring base field |
| cmd_ring_ctl | input | 32 | Descriptor ring control word |
| cmd_wb_hi | input | 32 | Writeback address, high word |
| cmd_wb_lo | input | 32 | Writeback address, low word |
| cmd_rptr | input | 64 | Saved read pointer |
| cmd_wptr | input | 64 | Saved write pointer |
| prog_valid | input | 1 | Live pointer update |
| prog_slot | input | IDX_W | Slot being updated |
| prog_rptr | input | 64 | New read pointer |
| prog_wptr | input | 64 | New write pointer |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | 64 | Write byte address |
| mem_wr_data | output | 64 | Write data |
| err_pulse | output | 1 | Map with no free slot, or unmap with no match |
| warn_pulse | output | 1 | Unmap of a slot without a descriptor address |
| view_slot | input | IDX_W | Slot shown on the view port |
| view_valid | output | 1 | Viewed slot valid |
| view_busy | output | 1 | Viewed slot busy flag |
| view_key | output | DBO_W+2 | Viewed slot doorbell key |
| view_desc | output | 64 | Viewed slot descriptor address |
| view_base | output | 64 | Viewed slot ring base |
| view_size | output | 64 | Viewed slot ring size |
| view_rptr | output | 64 | Viewed slot read pointer |
| view_wptr | output | 64 | Viewed slot write pointer |
| view_wbaddr | output | 64 | Viewed slot writeback address |

## Verification
Map sequences fill both slots and then ask for a third, which tells lowest-free allocation apart from a full table. Field values carry noise bits next to the size field, so a wrong slice of the control word shows up. Unmaps are tried with a matching key, a key that matches nothing and a descriptor address of zero, and run against a memory port whose ready signal stalls at random. This separates the write order, the hold under back-pressure and the moment the slot is freed. A remap after a progress update shows that live pointers, not zeros, are saved and restored. Drains over full, partly filled and empty tables, one of which includes a slot without a descriptor, show the visiting order and the skipping of free slots.

// File: rtl/qctx_pkg.sv
package qctx_pkg;
  localparam int ADDR_W  = 64;
  localparam int PTR_W   = 64;
  localparam int CTL_W   = 32;
  localparam int HALF_W  = 32;
  localparam int BASE_SH = 8;
  localparam int SZ_LO   = 1;
  localparam int SZ_HI   = 6;
  localparam logic [ADDR_W-1:0] RPTR_OFS = 64'h10;
  localparam logic [ADDR_W-1:0] WPTR_OFS = 64'h18;

  typedef enum logic [1:0] {OP_MAP = 2'd0, OP_UNMAP = 2'd1, OP_DRAIN = 2'd2, OP_NONE = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WRP, ST_WWP} seq_e;

  typedef struct packed {
    logic [ADDR_W-1:0] desc;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic [PTR_W-1:0]  rptr;
    logic [PTR_W-1:0]  wptr;
    logic [ADDR_W-1:0] wbaddr;
  } ctx_t;

  function automatic logic [ADDR_W-1:0] ring_bytes(input logic [CTL_W-1:0] ctl);
    return ADDR_W'(4) << ctl[SZ_HI:SZ_LO];
  endfunction
endpackage

// File: rtl/qctx_decode.sv
module qctx_decode
  import qctx_pkg::*;
(
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [CTL_W-1:0]  ring_ctl,
  input  logic [HALF_W-1:0] wb_hi,
  input  logic [HALF_W-1:0] wb_lo,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [PTR_W-1:0]  wptr,
  output ctx_t              ctx
);
  always_comb begin
    ctx.desc   = desc_addr;
    ctx.base   = ring_base << BASE_SH;
    ctx.size   = ring_bytes(ring_ctl);
    ctx.rptr   = rptr;
    ctx.wptr   = wptr;
    ctx.wbaddr = {wb_hi, wb_lo};
  end
endmodule

// File: rtl/qctx_pick.sv
module qctx_pick #(
  parameter  int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/qctx_slot_file.sv
module qctx_slot_file
  import qctx_pkg::*;
#(
  parameter  int NSLOT = 2,
  parameter  int KEY_W = 14,
  localparam int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  ctx_t             ld_ctx,
  input  logic [KEY_W-1:0] ld_key,
  input  logic             free_en,
  input  logic [IW-1:0]    free_idx,
  input  logic             upd_en,
  input  logic [IW-1:0]    upd_idx,
  input  logic [PTR_W-1:0] upd_rptr,
  input  logic [PTR_W-1:0] upd_wptr,
  input  logic [KEY_W-1:0] cmp_key,
  output logic [NSLOT-1:0] vld,
  output logic [NSLOT-1:0] match,
  input  logic [IW-1:0]    rd_idx,
  output ctx_t             rd_ctx,
  output logic             rd_occ,
  input  logic [IW-1:0]    pk_idx,
  output ctx_t             pk_ctx,
  output logic [KEY_W-1:0] pk_key,
  output logic             pk_vld,
  output logic             pk_busy
);
  ctx_t             ctx_a [NSLOT];
  logic [KEY_W-1:0] key_a [NSLOT];
  logic [NSLOT-1:0] busy_v;
  logic [NSLOT-1:0] occ;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic             v_q;
    logic             b_q;
    ctx_t             c_q;
    logic [KEY_W-1:0] k_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        b_q <= 1'b0;
        c_q <= '0;
        k_q <= '0;
      end else if (ld_en && ld_idx == IW'(s)) begin
        v_q <= 1'b1;
        b_q <= 1'b0;
        c_q <= ld_ctx;
        k_q <= ld_key;
      end else if (free_en && free_idx == IW'(s)) begin
        v_q <= 1'b0;
        b_q <= 1'b0;
        k_q <= '0;
      end else if (upd_en && upd_idx == IW'(s) && v_q) begin
        c_q.rptr <= upd_rptr;
        c_q.wptr <= upd_wptr;
        b_q      <= 1'b1;
      end
    end

    assign vld[s]    = v_q;
    assign busy_v[s] = b_q;
    assign ctx_a[s]  = c_q;
    assign key_a[s]  = k_q;
    assign occ[s]    = (k_q != '0);
    assign match[s]  = v_q && (k_q == cmp_key);
  end

  assign rd_ctx  = ctx_a[rd_idx];
  assign rd_occ  = occ[rd_idx];
  assign pk_ctx  = ctx_a[pk_idx];
  assign pk_key  = key_a[pk_idx];
  assign pk_vld  = vld[pk_idx];
  assign pk_busy = busy_v[pk_idx];
endmodule

// File: rtl/qctx_seq.sv
module qctx_seq
  import qctx_pkg::*;
#(
  parameter  int NSLOT = 2,
  localparam int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  logic [1:0]        cmd_op,
  input  logic              free_hit,
  input  logic [IW-1:0]     free_idx_in,
  input  logic              un_hit,
  input  logic [IW-1:0]     un_idx,
  input  ctx_t              rd_ctx,
  input  logic              rd_occ,
  output logic [IW-1:0]     rd_idx,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTR_W-1:0]  wr_data,
  output logic              ready,
  output logic              ld_en,
  output logic [IW-1:0]     ld_idx,
  output logic              free_en,
  output logic [IW-1:0]     free_idx,
  output logic              err_q,
  output logic              warn_q
);
  localparam logic [IW-1:0] LAST = IW'(NSLOT - 1);

  seq_e          st_q;
  logic [IW-1:0] cur_q;
  logic          drain_q;

  logic is_map, is_unmap, is_drain, no_desc;
  assign is_map   = cmd_fire && (cmd_op == OP_MAP);
  assign is_unmap = cmd_fire && (cmd_op == OP_UNMAP);
  assign is_drain = cmd_fire && (cmd_op == OP_DRAIN);
  assign no_desc  = (rd_ctx.desc == '0);

  assign ready    = (st_q == ST_IDLE);
  assign wr_valid = (st_q == ST_WRP) || (st_q == ST_WWP);
  assign rd_idx   = (st_q == ST_IDLE) ? un_idx : cur_q;
  assign ld_en    = (st_q == ST_IDLE) && is_map && free_hit;
  assign ld_idx   = free_idx_in;
  assign free_idx = rd_idx;

  always_comb begin
    free_en = 1'b0;
    case (st_q)
      ST_IDLE: free_en = is_unmap && un_hit && no_desc;
      ST_SCAN: free_en = rd_occ && no_desc;
      ST_WWP:  free_en = wr_ready;
      default: free_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      drain_q <= 1'b0;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      err_q  <= 1'b0;
      warn_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (is_map && !free_hit) err_q <= 1'b1;
          if (is_unmap) begin
            if (!un_hit) err_q <= 1'b1;
            else if (no_desc) warn_q <= 1'b1;
            else begin
              cur_q   <= un_idx;
              drain_q <= 1'b0;
              wr_addr <= rd_ctx.desc + RPTR_OFS;
              wr_data <= rd_ctx.rptr;
              st_q    <= ST_WRP;
            end
          end
          if (is_drain) begin
            cur_q   <= '0;
            drain_q <= 1'b1;
            st_q    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (rd_occ && !no_desc) begin
            wr_addr <= rd_ctx.desc + RPTR_OFS;
            wr_data <= rd_ctx.rptr;
            st_q    <= ST_WRP;
          end else begin
            if (rd_occ) warn_q <= 1'b1;
            if (cur_q == LAST) st_q <= ST_IDLE;
            else cur_q <= cur_q + 1'b1;
          end
        end
        ST_WRP: begin
          if (wr_ready) begin
            wr_addr <= rd_ctx.desc + WPTR_OFS;
            wr_data <= rd_ctx.wptr;
            st_q    <= ST_WWP;
          end
        end
        ST_WWP: begin
          if (wr_ready) begin
            if (drain_q && cur_q != LAST) begin
              cur_q <= cur_q + 1'b1;
              st_q  <= ST_SCAN;
            end else begin
              drain_q <= 1'b0;
              st_q    <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qctx_mgr.sv
module qctx_mgr
  import qctx_pkg::*;
#(
  parameter  int NSLOT = 2,
  parameter  int DBO_W = 12,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int KEY_W = DBO_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DBO_W-1:0]  cmd_db_ofs,
  input  logic [ADDR_W-1:0] cmd_desc_addr,
  input  logic [ADDR_W-1:0] cmd_ring_base,
  input  logic [CTL_W-1:0]  cmd_ring_ctl,
  input  logic [HALF_W-1:0] cmd_wb_hi,
  input  logic [HALF_W-1:0] cmd_wb_lo,
  input  logic [PTR_W-1:0]  cmd_rptr,
  input  logic [PTR_W-1:0]  cmd_wptr,
  input  logic              prog_valid,
  input  logic [IDX_W-1:0]  prog_slot,
  input  logic [PTR_W-1:0]  prog_rptr,
  input  logic [PTR_W-1:0]  prog_wptr,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [PTR_W-1:0]  mem_wr_data,
  output logic              err_pulse,
  output logic              warn_pulse,
  input  logic [IDX_W-1:0]  view_slot,
  output logic              view_valid,
  output logic              view_busy,
  output logic [KEY_W-1:0]  view_key,
  output logic [ADDR_W-1:0] view_desc,
  output logic [ADDR_W-1:0] view_base,
  output logic [ADDR_W-1:0] view_size,
  output logic [PTR_W-1:0]  view_rptr,
  output logic [PTR_W-1:0]  view_wptr,
  output logic [ADDR_W-1:0] view_wbaddr
);
  ctx_t             map_ctx, rd_ctx, pk_ctx;
  logic [KEY_W-1:0] key_in;
  logic [NSLOT-1:0] slot_vld, slot_match;
  logic             free_hit, un_hit, rd_occ;
  logic [IDX_W-1:0] free_pick, un_idx, rd_idx;
  logic             ld_en, free_en;
  logic [IDX_W-1:0] ld_idx, free_idx;
  logic             cmd_fire;

  assign key_in   = {cmd_db_ofs, 2'b00};
  assign cmd_fire = cmd_valid && cmd_ready;

  qctx_decode u_dec (
    .desc_addr(cmd_desc_addr), .ring_base(cmd_ring_base), .ring_ctl(cmd_ring_ctl),
    .wb_hi(cmd_wb_hi), .wb_lo(cmd_wb_lo), .rptr(cmd_rptr), .wptr(cmd_wptr),
    .ctx(map_ctx)
  );

  qctx_pick #(.N(NSLOT)) u_free (.req(~slot_vld), .found(free_hit), .idx(free_pick));
  qctx_pick #(.N(NSLOT)) u_hit  (.req(slot_match), .found(un_hit), .idx(un_idx));

  qctx_slot_file #(.NSLOT(NSLOT), .KEY_W(KEY_W)) u_slots (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_ctx(map_ctx), .ld_key(key_in),
    .free_en(free_en), .free_idx(free_idx),
    .upd_en(prog_valid), .upd_idx(prog_slot), .upd_rptr(prog_rptr), .upd_wptr(prog_wptr),
    .cmp_key(key_in), .vld(slot_vld), .match(slot_match),
    .rd_idx(rd_idx), .rd_ctx(rd_ctx), .rd_occ(rd_occ),
    .pk_idx(view_slot), .pk_ctx(pk_ctx), .pk_key(view_key),
    .pk_vld(view_valid), .pk_busy(view_busy)
  );

  qctx_seq #(.NSLOT(NSLOT)) u_seq (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .cmd_op(cmd_op),
    .free_hit(free_hit), .free_idx_in(free_pick), .un_hit(un_hit), .un_idx(un_idx),
    .rd_ctx(rd_ctx), .rd_occ(rd_occ), .rd_idx(rd_idx),
    .wr_ready(mem_wr_ready), .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .ready(cmd_ready), .ld_en(ld_en), .ld_idx(ld_idx),
    .free_en(free_en), .free_idx(free_idx), .err_q(err_pulse), .warn_q(warn_pulse)
  );

  assign view_desc   = pk_ctx.desc;
  assign view_base   = pk_ctx.base;
  assign view_size   = pk_ctx.size;
  assign view_rptr   = pk_ctx.rptr;
  assign view_wptr   = pk_ctx.wptr;
  assign view_wbaddr = pk_ctx.wbaddr;
endmodule

// File: rtl/qctx_mgr_chk.sv
module qctx_mgr_chk #(
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             mem_wr_valid,
  input logic             mem_wr_ready,
  input logic [63:0]      mem_wr_addr,
  input logic [63:0]      mem_wr_data,
  input logic             err_pulse,
  input logic             warn_pulse,
  input logic [NSLOT-1:0] slot_vld
);
  // R6
  hold_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
  // R7
  stall_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> !cmd_ready);
  // R1
  full_map_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_op == 2'd0 && (&slot_vld) |=> err_pulse && $stable(slot_vld));
  // R1
  map_take_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_op == 2'd0 && !(&slot_vld)
    |=> !err_pulse && $countones(slot_vld) == $countones($past(slot_vld)) + 1);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_pulse, warn_pulse}));
endmodule

bind qctx_mgr qctx_mgr_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .err_pulse(err_pulse), .warn_pulse(warn_pulse), .slot_vld(slot_vld)
);

// File: tb/qctx_mgr_test.sv
`timescale 1ns/1ps
module qctx_mgr_test;
  localparam int NS = 2;
  localparam int DW = 12;
  localparam int KW = DW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [DW-1:0] cmd_db_ofs = 0;
  logic [63:0] cmd_desc_addr = 0, cmd_ring_base = 0, cmd_rptr = 0, cmd_wptr = 0;
  logic [31:0] cmd_ring_ctl = 0, cmd_wb_hi = 0, cmd_wb_lo = 0;
  logic prog_valid = 0;
  logic [0:0] prog_slot = 0, view_slot = 0;
  logic [63:0] prog_rptr = 0, prog_wptr = 0;
  logic mem_wr_valid, mem_wr_ready = 1, err_pulse, warn_pulse;
  logic [63:0] mem_wr_addr, mem_wr_data;
  logic view_valid, view_busy;
  logic [KW-1:0] view_key;
  logic [63:0] view_desc, view_base, view_size, view_rptr, view_wptr, view_wbaddr;

  qctx_mgr #(.NSLOT(NS), .DBO_W(DW)) uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model
  bit m_v[NS], m_p[NS];
  logic [KW-1:0] m_k[NS];
  logic [63:0] m_desc[NS], m_base[NS], m_size[NS], m_rp[NS], m_wp[NS], m_wb[NS];
  typedef struct { int kind; int slot; logic [63:0] a; logic [63:0] d; bit fr; } step_t;
  step_t q[$];
  bit e_err, e_warn;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic void m_free(int s);
    m_v[s] = 0; m_p[s] = 0; m_k[s] = '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin
        m_v[s] = 0; m_p[s] = 0; m_k[s] = '0; m_desc[s] = 0; m_base[s] = 0;
        m_size[s] = 0; m_rp[s] = 0; m_wp[s] = 0; m_wb[s] = 0;
      end
      q.delete(); e_err = 0; e_warn = 0;
    end else begin
      bit rdy;
      rdy = (q.size() == 0);
      e_err = 0; e_warn = 0;
      if (prog_valid && m_v[prog_slot]) begin
        m_rp[prog_slot] = prog_rptr; m_wp[prog_slot] = prog_wptr; m_p[prog_slot] = 1;
      end
      if (!rdy) begin
        step_t h;
        h = q[0];
        if (h.kind == 0) begin
          if (mem_wr_ready) begin
            void'(q.pop_front());
            if (h.fr) m_free(h.slot);
          end
        end else begin
          void'(q.pop_front());
          if (m_k[h.slot] != 0) begin
            if (m_desc[h.slot] == 0) begin
              e_warn = 1; m_free(h.slot);
            end else begin
              q.push_front('{0, h.slot, m_desc[h.slot] + 64'h18, m_wp[h.slot], 1});
              q.push_front('{0, h.slot, m_desc[h.slot] + 64'h10, m_rp[h.slot], 0});
            end
          end
        end
      end else if (cmd_valid) begin
        logic [KW-1:0] key;
        int hit;
        key = {cmd_db_ofs, 2'b00};
        hit = -1;
        if (cmd_op == 2'd0) begin
          for (int s = NS - 1; s >= 0; s--) if (!m_v[s]) hit = s;
          if (hit < 0) e_err = 1;
          else begin
            m_v[hit] = 1; m_p[hit] = 0; m_k[hit] = key; m_desc[hit] = cmd_desc_addr;
            m_base[hit] = cmd_ring_base << 8;
            m_size[hit] = 64'd4 << ((cmd_ring_ctl >> 1) & 32'h3F);
            m_rp[hit] = cmd_rptr; m_wp[hit] = cmd_wptr;
            m_wb[hit] = {cmd_wb_hi, cmd_wb_lo};
          end
        end else if (cmd_op == 2'd1) begin
          for (int s = NS - 1; s >= 0; s--) if (m_v[s] && m_k[s] == key) hit = s;
          if (hit < 0) e_err = 1;
          else if (m_desc[hit] == 0) begin
            e_warn = 1; m_free(hit);
          end else begin
            q.push_back('{0, hit, m_desc[hit] + 64'h10, m_rp[hit], 0});
            q.push_back('{0, hit, m_desc[hit] + 64'h18, m_wp[hit], 1});
          end
        end else if (cmd_op == 2'd2) begin
          for (int s = 0; s < NS; s++) q.push_back('{1, s, 64'd0, 64'd0, 0});
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int s;
      bit ev;
      s = int'(view_slot);
      ev = (q.size() > 0) && (q[0].kind == 0);
      chk(cmd_ready == (q.size() == 0), "R7", "cmd_ready", 64'(cmd_ready), 64'(q.size() == 0));
      chk(err_pulse == e_err, "R1 R9", "err_pulse", 64'(err_pulse), 64'(e_err));
      chk(warn_pulse == e_warn, "R8", "warn_pulse", 64'(warn_pulse), 64'(e_warn));
      chk(mem_wr_valid == ev, "R6", "mem_wr_valid", 64'(mem_wr_valid), 64'(ev));
      if (ev) begin
        chk(mem_wr_addr == q[0].a, "R6", "mem_wr_addr", mem_wr_addr, q[0].a);
        chk(mem_wr_data == q[0].d, "R6 R12", "mem_wr_data", mem_wr_data, q[0].d);
      end
      chk(view_valid == m_v[s], "R5", "view_valid", 64'(view_valid), 64'(m_v[s]));
      chk(view_busy == m_p[s], "R12", "view_busy", 64'(view_busy), 64'(m_p[s]));
      chk(view_key == m_k[s], "R5", "view_key", 64'(view_key), 64'(m_k[s]));
      chk(view_desc == m_desc[s], "R5", "view_desc", view_desc, m_desc[s]);
      chk(view_base == m_base[s], "R2", "view_base", view_base, m_base[s]);
      chk(view_size == m_size[s], "R3", "view_size", view_size, m_size[s]);
      chk(view_wbaddr == m_wb[s], "R4", "view_wbaddr", view_wbaddr, m_wb[s]);
      chk(view_rptr == m_rp[s], "R5", "view_rptr", view_rptr, m_rp[s]);
      chk(view_wptr == m_wp[s], "R5", "view_wptr", view_wptr, m_wp[s]);
    end
  end

  // input pacing: view slot alternates, memory ready stalls in stall mode
  always @(negedge clk) begin
    #1;
    cyc++;
    view_slot <= ~view_slot;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wr_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic issue(input logic [1:0] op, input logic [DW-1:0] dbo, input logic [63:0] desc,
                       input logic [63:0] base, input logic [31:0] ctl, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [63:0] rp, input logic [63:0] wp);
    @(negedge clk); #2;
    cmd_op = op; cmd_db_ofs = dbo; cmd_desc_addr = desc; cmd_ring_base = base;
    cmd_ring_ctl = ctl; cmd_wb_hi = hi; cmd_wb_lo = lo; cmd_rptr = rp; cmd_wptr = wp;
    cmd_valid = 1;
    while (!cmd_ready) begin @(negedge clk); #2; end
    @(negedge clk); #2;
    cmd_valid = 0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic view_at(int s);
    @(negedge clk); #2;
    while (int'(view_slot) != s) begin @(negedge clk); #2; end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R11: reset state seen at the ports
    chk(cmd_ready === 1'b1, "R11", "ready after reset", 64'(cmd_ready), 64'd1);
    chk(mem_wr_valid === 1'b0, "R11", "no write after reset", 64'(mem_wr_valid), 64'd0);
    chk(view_valid === 1'b0 && view_key == '0, "R11", "slot clear after reset", 64'(view_key), 64'd0);

    // R2 R3 R4 R5: map two queues, noise bits around the size field
    issue(2'd0, 12'd5, 64'h1000, 64'h0012_3456_789A_BCDE, 32'hFFFF_FF87, 32'hDEAD_0001, 32'h0000_BEE0, 64'h40, 64'h80);
    issue(2'd0, 12'd9, 64'h2000, 64'h0000_0000_0001_0000, 32'h0000_007E, 32'h0, 32'h1234_5678, 64'h7, 64'h9);
    // R1: third map with a full table
    issue(2'd0, 12'd11, 64'h3000, 64'h1, 32'h2, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    // R12: engine advances slot 0
    @(negedge clk); #2;
    prog_valid = 1; prog_slot = 1'b0; prog_rptr = 64'h100; prog_wptr = 64'h140;
    @(negedge clk); #2;
    prog_valid = 0;
    // R9: unmap with an unknown key
    issue(2'd1, 12'd7, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    // R6 R7: unmap slot 0 under back-pressure
    stall_mode = 1;
    issue(2'd1, 12'd5, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    view_at(0);
    chk(view_valid === 1'b0 && view_key == '0, "R7", "slot 0 freed after writeback", 64'(view_key), 64'd0);
    // remap with saved pointers
    issue(2'd0, 12'd5, 64'h1000, 64'h0012_3456_789A_BCDE, 32'h87, 32'hDEAD_0001, 32'h0000_BEE0, 64'h100, 64'h140);
    settle(2);
    view_at(0);
    chk(view_rptr == 64'h100, "R5", "restored rptr", view_rptr, 64'h100);
    // R8: slot without descriptor address
    issue(2'd1, 12'd9, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    issue(2'd0, 12'd3, 64'h0, 64'h5, 32'h4, 32'h0, 32'h0, 64'h3, 64'h4);
    settle(1);
    issue(2'd1, 12'd3, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    view_at(1);
    chk(view_valid === 1'b0, "R8", "descriptorless slot freed", 64'(view_valid), 64'd0);
    // R10: drain a full table, one slot with no descriptor
    issue(2'd0, 12'd20, 64'h0, 64'h6, 32'hA, 32'h0, 32'h0, 64'h1, 64'h2);
    issue(2'd2, 12'd0, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    view_at(0);
    chk(view_valid === 1'b0, "R10", "slot 0 drained", 64'(view_valid), 64'd0);
    view_at(1);
    chk(view_valid === 1'b0, "R10", "slot 1 drained", 64'(view_valid), 64'd0);
    // R10: drain with only slot 1 occupied, then an empty drain
    stall_mode = 0;
    issue(2'd0, 12'd30, 64'h4000, 64'h8, 32'hC, 32'h1, 32'h2, 64'h11, 64'h22);
    issue(2'd0, 12'd31, 64'h5000, 64'h9, 32'hE, 32'h3, 32'h4, 64'h33, 64'h44);
    issue(2'd1, 12'd30, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(1);
    issue(2'd2, 12'd0, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    issue(2'd2, 12'd0, 64'h0, 64'h0, 32'h0, 32'h0, 32'h0, 64'h0, 64'h0);
    settle(2);
    view_at(1);
    chk(view_valid === 1'b0 && view_key == '0, "R10", "table empty after drains", 64'(view_key), 64'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule